// File: doc/BRIEF.md
# Bit Count and Field Manipulation Unit

This is a 32-bit integer execution unit for bit-level work. It counts leading zeros or leading ones, pulls a bit field out of a word, drops a bit field into a word, swaps the bytes inside each halfword, and sign-extends the low byte or the low halfword. A caller supplies an operation code, two 32-bit operands and two 5-bit field values taken from the instruction word, then pulses `start`. One clock later the registered result appears with a one-cycle `done` pulse.

The two field inputs have a different meaning for each operation:
- For extract, `fld_hi` is the field size minus one and `fld_lo` is the position of the field's lowest bit.
- For insert, `fld_hi` is the absolute top bit of the field and `fld_lo` is its lowest bit.
- For the shuffle group, `fld_lo` carries the sub-operation code.

Field settings that make no sense raise a `bad_op` flag and give a zero result. Operation codes outside the defined set do the same.

Top module: `bitfield_unit`

## Requirements
- R1: While `rst_n` is low, `result`, `done` and `bad_op` are all zero, and they stay zero until the first `start`.
- R2: `done` is high in exactly the cycle after each cycle in which `start` was high. `result` and `bad_op` change only in that cycle and hold their values otherwise, whatever the inputs do.
- R3: With `op` = 0 (leading-zero count), the result is 31 minus the index of the highest set bit of `rs`, or 32 when `rs` is zero.
- R4: With `op` = 1 (leading-one count), the result is 31 minus the index of the highest clear bit of `rs`, or 32 when `rs` is all ones.
- R5: With `op` = 2 (extract), the result holds `rs` bits `fld_lo+fld_hi` down to `fld_lo`, right-aligned, with the upper bits zero. When `fld_lo+fld_hi` exceeds 31, `bad_op` is 1 and the result is zero.
- R6: With `op` = 3 (insert), the result equals `rt` with bits `fld_hi`..`fld_lo` replaced by `rs` bits `(fld_hi-fld_lo)`..0. When `fld_hi` < `fld_lo`, `bad_op` is 1 and the result is zero.
- R7: With `op` = 4 and `fld_lo` = 0x02, the result is {rt[23:16], rt[31:24], rt[7:0], rt[15:8]}.
- R8: With `op` = 4, `fld_lo` = 0x10 gives `rt[7]` copied into bits 31:8 above `rt[7:0]`, and `fld_lo` = 0x18 gives `rt[15]` copied into bits 31:16 above `rt[15:0]`. Any other `fld_lo` code sets `bad_op` and gives a zero result.
- R9: `op` values 5, 6 and 7 set `bad_op` and give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts an operation on the current inputs |
| op | input | 3 | Operation: 0 leading zeros, 1 leading ones, 2 extract, 3 insert, 4 shuffle |
| rs | input | 32 | First source operand |
| rt | input | 32 | Second source operand (insert target, shuffle source) |
| fld_hi | input | 5 | Extract: size minus one; insert: top bit position |
| fld_lo | input | 5 | Low bit position, or shuffle sub-code |
| result | output | 32 | Registered result |
| done | output | 1 | One-cycle pulse, one clock after `start` |
| bad_op | output | 1 | Registered flag for invalid field or code |

## Verification
The counters are driven with all-zero, all-one, single-bit and random words. These patterns separate the 32 saturation case from an off-by-one in the index arithmetic, and they separate the leading-ones path from the leading-zeros path. Extract and insert are tried at the two ends of the word, with one-bit fields, with a full-width field, and with settings just past the legal limit, so that a wrong mask width or a wrong validity bound shows up. The shuffle codes are tried with the sign bits set and clear, and one unused code is included. Idle cycles with changing inputs show that the result holds when no operation is started.

// File: rtl/bitfield_unit.sv
module bitfield_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [31:0] rs,
  input  logic [31:0] rt,
  input  logic [4:0]  fld_hi,
  input  logic [4:0]  fld_lo,
  output logic [31:0] result,
  output logic        done,
  output logic        bad_op
);
  localparam logic [2:0] OP_CLZ = 3'd0;
  localparam logic [2:0] OP_CLO = 3'd1;
  localparam logic [2:0] OP_EXT = 3'd2;
  localparam logic [2:0] OP_INS = 3'd3;
  localparam logic [2:0] OP_SHF = 3'd4;
  localparam logic [4:0] SH_SWAP = 5'h02;
  localparam logic [4:0] SH_SEB  = 5'h10;
  localparam logic [4:0] SH_SEH  = 5'h18;

  logic [31:0] cnt_src;
  logic [5:0]  lead;
  logic [5:0]  ext_top;
  logic [5:0]  ins_w;
  logic [31:0] ext_mask, ins_mask;
  logic [31:0] nxt_res;
  logic        nxt_bad;

  assign cnt_src  = (op == OP_CLO) ? ~rs : rs;
  assign ext_top  = {1'b0, fld_hi} + {1'b0, fld_lo};
  assign ext_mask = 32'((33'd1 << ({1'b0, fld_hi} + 6'd1)) - 33'd1);
  assign ins_w    = {1'b0, fld_hi} - {1'b0, fld_lo} + 6'd1;
  assign ins_mask = 32'((33'd1 << ins_w) - 33'd1) << fld_lo;

  always_comb begin
    lead = 6'd32;
    for (int i = 0; i < 32; i++)
      if (cnt_src[i]) lead = 6'(31 - i);
  end

  always_comb begin
    nxt_res = '0;
    nxt_bad = 1'b0;
    case (op)
      OP_CLZ, OP_CLO: nxt_res = {26'd0, lead};
      OP_EXT:
        if (ext_top > 6'd31) nxt_bad = 1'b1;
        else nxt_res = (rs >> fld_lo) & ext_mask;
      OP_INS:
        if (fld_hi < fld_lo) nxt_bad = 1'b1;
        else nxt_res = (rt & ~ins_mask) | ((rs << fld_lo) & ins_mask);
      OP_SHF:
        case (fld_lo)
          SH_SWAP: nxt_res = {rt[23:16], rt[31:24], rt[7:0], rt[15:8]};
          SH_SEB:  nxt_res = {{24{rt[7]}}, rt[7:0]};
          SH_SEH:  nxt_res = {{16{rt[15]}}, rt[15:0]};
          default: nxt_bad = 1'b1;
        endcase
      default: nxt_bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
      bad_op <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result <= nxt_res;
        bad_op <= nxt_bad;
      end
    end
  end

  a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r2_done_only_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(bad_op)));
  a_r3_zero_word_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_CLZ && rs == 32'd0) |=> (result == 32'd32 && !bad_op));
  a_r4_ones_word_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_CLO && rs == 32'hFFFF_FFFF) |=> (result == 32'd32 && !bad_op));
  a_r6_bad_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> (result == 32'd0));
  a_r9_unused_op_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op > OP_SHF) |=> bad_op);
endmodule

// File: tb/bitfield_unit_bench.sv
module bitfield_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] rs = '0, rt = '0;
  logic [4:0]  fld_hi = '0, fld_lo = '0;
  logic [31:0] result;
  logic        done, bad_op;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_req = "R1";
  logic [31:0] lfsr = 32'hACE1_2468;

  logic [31:0] m_res = '0;
  logic        m_done = 1'b0, m_bad = 1'b0;

  always #2 clk = ~clk;

  bitfield_unit u_bitfield_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rs(rs), .rt(rt),
    .fld_hi(fld_hi), .fld_lo(fld_lo), .result(result), .done(done), .bad_op(bad_op)
  );

  function automatic logic [32:0] ref_calc(input logic [2:0] o, input logic [31:0] a,
      input logic [31:0] b, input int hi, input int lo);
    logic [31:0] r;
    int n;
    r = '0;
    case (o)
      3'd0, 3'd1: begin
        n = 0;
        while (n < 32 && a[31-n] == (o == 3'd1)) n++;
        return {1'b0, 32'(n)};
      end
      3'd2: begin
        if (hi + lo > 31) return {1'b1, 32'd0};
        for (int i = 0; i <= hi; i++) r[i] = a[lo+i];
        return {1'b0, r};
      end
      3'd3: begin
        if (hi < lo) return {1'b1, 32'd0};
        r = b;
        for (int i = lo; i <= hi; i++) r[i] = a[i-lo];
        return {1'b0, r};
      end
      3'd4: begin
        if (lo == 2) return {1'b0, b[23:16], b[31:24], b[7:0], b[15:8]};
        if (lo == 16) begin
          r = b[7] ? 32'hFFFF_FF00 : 32'd0;
          r[7:0] = b[7:0];
          return {1'b0, r};
        end
        if (lo == 24) begin
          r = b[15] ? 32'hFFFF_0000 : 32'd0;
          r[15:0] = b[15:0];
          return {1'b0, r};
        end
        return {1'b1, 32'd0};
      end
      default: return {1'b1, 32'd0};
    endcase
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_res <= '0; m_done <= 1'b0; m_bad <= 1'b0;
    end else begin
      m_done <= start;
      if (start) {m_bad, m_res} <= ref_calc(op, rs, rt, int'(fld_hi), int'(fld_lo));
    end
  end

  always @(negedge clk) begin
    checks++;
    if (done !== m_done || result !== m_res || bad_op !== m_bad) begin
      errors++;
      $display("FAIL %s: done/bad/result got %b/%b/%h expected %b/%b/%h",
               cur_req, done, bad_op, result, m_done, m_bad, m_res);
    end
  end

  task automatic go(input string req, input logic [2:0] o, input logic [31:0] a,
      input logic [31:0] b, input logic [4:0] hi, input logic [4:0] lo);
    @(negedge clk);
    cur_req = req;
    op = o; rs = a; rt = b; fld_hi = hi; fld_lo = lo; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rs = ~rs; rt = rt ^ 32'h5A5A_5A5A; op = op + 3'd1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    cur_req = "R1";
    checks++;
    if (result !== 32'd0 || done !== 1'b0 || bad_op !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs got %h/%b/%b expected 0/0/0", result, done, bad_op);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    go("R3", 3'd0, 32'h0000_0000, '0, 5'd0, 5'd0);
    go("R3", 3'd0, 32'h0000_0001, '0, 5'd0, 5'd0);
    go("R3", 3'd0, 32'h8000_0000, '0, 5'd0, 5'd0);
    go("R3", 3'd0, 32'h0001_0F00, '0, 5'd0, 5'd0);
    go("R4", 3'd1, 32'hFFFF_FFFF, '0, 5'd0, 5'd0);
    go("R4", 3'd1, 32'h0000_0000, '0, 5'd0, 5'd0);
    go("R4", 3'd1, 32'hFFF0_0000, '0, 5'd0, 5'd0);
    go("R4", 3'd1, 32'hFFFF_FFFE, '0, 5'd0, 5'd0);
    go("R5", 3'd2, 32'hDEAD_BEEF, '0, 5'd7, 5'd4);
    go("R5", 3'd2, 32'hDEAD_BEEF, '0, 5'd31, 5'd0);
    go("R5", 3'd2, 32'h8000_0000, '0, 5'd0, 5'd31);
    go("R5", 3'd2, 32'hFFFF_FFFF, '0, 5'd1, 5'd31);
    go("R5", 3'd2, 32'hFFFF_FFFF, '0, 5'd16, 5'd16);
    go("R6", 3'd3, 32'h0000_00AB, 32'h1234_5678, 5'd15, 5'd8);
    go("R6", 3'd3, 32'hCAFE_F00D, 32'h1234_5678, 5'd31, 5'd0);
    go("R6", 3'd3, 32'hFFFF_FFFF, 32'h0000_0000, 5'd5, 5'd5);
    go("R6", 3'd3, 32'hFFFF_FFFF, 32'h0000_0000, 5'd31, 5'd31);
    go("R6", 3'd3, 32'hFFFF_FFFF, 32'h1234_5678, 5'd3, 5'd4);
    go("R7", 3'd4, '0, 32'h1122_3344, 5'd0, 5'h02);
    go("R8", 3'd4, '0, 32'h0000_0080, 5'd0, 5'h10);
    go("R8", 3'd4, '0, 32'hFFFF_FF7F, 5'd0, 5'h10);
    go("R8", 3'd4, '0, 32'h0000_8001, 5'd0, 5'h18);
    go("R8", 3'd4, '0, 32'hFFFF_7FFF, 5'd0, 5'h18);
    go("R8", 3'd4, '0, 32'h1122_3344, 5'd0, 5'h03);
    go("R9", 3'd5, 32'h1, 32'h2, 5'd1, 5'd1);
    go("R9", 3'd6, 32'h1, 32'h2, 5'd1, 5'd1);
    go("R9", 3'd7, 32'h1, 32'h2, 5'd1, 5'd1);

    cur_req = "R2";
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rs = rs + 32'd77; rt = ~rt; op = 3'(k);
    end
    @(negedge clk);
    op = 3'd0; rs = 32'h0000_0100; start = 1'b1;
    @(negedge clk);
    op = 3'd1; rs = 32'h0000_0000;
    @(negedge clk);
    start = 1'b0;

    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      go("RND", lfsr[2:0], lfsr * 32'd2654435761, lfsr ^ 32'h9E37_79B9,
         lfsr[12:8], (lfsr[2:0] == 3'd4) ? {lfsr[15:14], 3'b000} | 5'h02 & {5{lfsr[13]}} : lfsr[20:16]);
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(negedge clk) begin
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles got %0d expected below 20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule